// File: doc/BRIEF.md
# Linked-Descriptor DMA Channel Sequencer

This block runs one DMA channel by walking a chain of descriptors that sit in host memory. Software first loads a 64-bit pointer to the first descriptor. It then issues one control write that sets enable, scatter-gather mode and start together. From that point the sequencer works on its own. It reads each eight-word descriptor through a 32-bit word-read port and turns it into a single transfer command (host address, byte count, direction) for an external data mover. It waits for that mover to acknowledge completion and then follows the descriptor's link to the next entry.

The link word carries the per-descriptor flags in its low bits, because descriptors are 32-byte aligned and those bits are free. Bit 1 marks the end of the chain, bit 2 requests an interrupt when the entry completes, and bit 3 selects the direction. A chain whose last link points back to an earlier entry runs forever until software patches the link or aborts the channel. A completion interrupt and an externally pulsed event interrupt share one interrupt output.

Top module: `sg_chain_engine`

## Requirements
- R1: After reset the control/status word reads 0x0000_0010: done set, every other bit clear. `irq`, `memRdReq` and `xferValid` are all low.
- R2: The descriptor pointer is written as a low word at register offset 0x0 and a high word at offset 0x4. The low word reads back with bits [4:0] forced to zero. The high word reads back unchanged.
- R3: The control/status word sits at offset 0x8. A chain starts only from a single write to it with bit 0 (enable), bit 1 (start) and bit 8 (scatter-gather mode) all set. A write that lacks any of the three starts no memory read and leaves done set.
- R4: For each descriptor the sequencer reads eight words at descriptor address + 4*k, for k = 0..7 in order. Word 0 is host address low, word 1 host address high, word 2 local, word 3 reserved, word 4 byte count, word 5 reserved, word 6 link low, word 7 link high. `memRdReq` stays high until `memRdValid` returns each word, and every read address is word aligned.
- R5: After the fetch, the sequencer presents one transfer command. It carries host address {word1, word0} and byte count word4. `xferToHost` is bit 3 of link-low (1 = write toward the host). The command is held stable until `xferReady`.
- R6: When bit 1 of link-low is clear, the next descriptor address is {link-high, link-low[31:5], 5'b0}. The sequencer follows it after `xferDone`, even when it points back to an entry already used.
- R7: A start clears done. Done is set again only by the `xferDone` of a descriptor whose link-low bit 1 is set.
- R8: When a descriptor with link-low bit 2 set completes (`xferDone`), control bit 5 becomes 1 and drives `irq`. Writing 1 to bit 5 clears it. Descriptors without bit 2 leave it at 0.
- R9: A pulse on `eventIn` sets control bit 6, and writing 1 to bit 6 clears it. Bit 6 drives `irq` only while control bit 10 is set.
- R10: A control write with bit 2 (abort) set stops the channel at once and sets done. No further memory read or transfer command is issued, and a late `xferDone` has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 4 | Register byte offset (0x0, 0x4, 0x8) |
| regWrData | input | 32 | Register write data |
| regRdData | output | 32 | Register read data for regAddr (combinational) |
| memRdReq | output | 1 | Descriptor word read request, held until memRdValid |
| memRdAddr | output | 64 | Byte address of the requested word |
| memRdValid | input | 1 | Read data valid, ends the current request |
| memRdData | input | 32 | Read data |
| xferValid | output | 1 | Transfer command valid |
| xferHostAddr | output | 64 | Transfer host address |
| xferBytes | output | 32 | Transfer byte count |
| xferToHost | output | 1 | 1 = write toward host, 0 = read from host |
| xferReady | input | 1 | Transfer command accepted |
| xferDone | input | 1 | Accepted transfer finished |
| eventIn | input | 1 | Event interrupt pulse |
| irq | output | 1 | Interrupt output |

## Verification
A start write takes effect at the next edge, so `memRdReq` is high from the following cycle. With a memory that answers in the same cycle, the eight words arrive on eight consecutive edges, and `xferValid` rises one cycle after the last word. The bench mover raises `xferReady` on the first falling edge where it sees `xferValid`. It pulses `xferDone` four cycles after acceptance, and done, bit 5 and the link are updated on that edge. The scoreboard compares each command at the falling edge where it is accepted. Register and done checks read the combinational read port one nanosecond after a falling edge, and the done-still-clear check is placed inside the four-cycle window between the last acceptance and its acknowledgement.

// File: rtl/sg_chain_pkg.sv
package sg_chain_pkg;

  localparam int ADDR_W = 64;
  localparam int WORD_W = 32;

  // control/status bit positions (software decodes these)
  localparam int CS_EN      = 0;
  localparam int CS_START   = 1;
  localparam int CS_ABORT   = 2;
  localparam int CS_DONE    = 4;
  localparam int CS_SGIRQ   = 5;
  localparam int CS_EVIRQ   = 6;
  localparam int CS_SGMODE  = 8;
  localparam int CS_EVIRQEN = 10;

  // link-low flag positions
  localparam int LK_EOC   = 1;
  localparam int LK_IRQ   = 2;
  localparam int LK_TOHST = 3;
  localparam int LK_ALIGN = 5;

  // descriptor word indices
  localparam int DW_HOST_LO = 0;
  localparam int DW_HOST_HI = 1;
  localparam int DW_BYTES   = 4;
  localparam int DW_LINK_LO = 6;
  localparam int DW_LINK_HI = 7;

  // register word index (regAddr[3:2])
  localparam logic [1:0] RA_PTR_LO = 2'd0;
  localparam logic [1:0] RA_PTR_HI = 2'd1;
  localparam logic [1:0] RA_CTRL   = 2'd2;

  typedef enum logic [1:0] {ST_IDLE, ST_FETCH, ST_ISSUE, ST_WAIT} engState_t;

  typedef struct packed {
    logic loadPtr;
    logic capWord;
    logic followNext;
  } dpStrobe_t;

endpackage

// File: rtl/sg_chain_dpath.sv
module sg_chain_dpath
  import sg_chain_pkg::*;
#(
  parameter int DESC_WORDS = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         stb,
  input  logic              ptrLoWr,
  input  logic              ptrHiWr,
  input  logic [WORD_W-1:0] wrData,
  input  logic [WORD_W-1:0] memRdData,
  output logic [WORD_W-1:0] ptrLoQ,
  output logic [WORD_W-1:0] ptrHiQ,
  output logic [ADDR_W-1:0] memRdAddr,
  output logic              lastWord,
  output logic              eocFlag,
  output logic              irqFlag,
  output logic              toHostFlag,
  output logic [ADDR_W-1:0] hostAddr,
  output logic [WORD_W-1:0] byteCount
);

  localparam int IDX_W = $clog2(DESC_WORDS);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(DESC_WORDS - 1);

  logic [WORD_W-1:LK_ALIGN] ptrLoR;
  logic [WORD_W-1:0]        ptrHiR;
  logic [ADDR_W-1:0]        curAddr;
  logic [IDX_W-1:0]         wordIdx;
  logic [WORD_W-1:0]        hostLoR, hostHiR, bytesR, linkLoR, linkHiR;
  logic [ADDR_W-1:0]        nextAddr;

  assign ptrLoQ    = {ptrLoR, {LK_ALIGN{1'b0}}};
  assign ptrHiQ    = ptrHiR;
  assign memRdAddr = curAddr + ADDR_W'({wordIdx, 2'b00});
  assign lastWord  = (wordIdx == LAST_IDX);
  assign nextAddr  = {linkHiR, linkLoR[WORD_W-1:LK_ALIGN], {LK_ALIGN{1'b0}}};
  assign eocFlag   = linkLoR[LK_EOC];
  assign irqFlag   = linkLoR[LK_IRQ];
  assign toHostFlag = linkLoR[LK_TOHST];
  assign hostAddr  = {hostHiR, hostLoR};
  assign byteCount = bytesR;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ptrLoR <= '0;
      ptrHiR <= '0;
    end else begin
      if (ptrLoWr) ptrLoR <= wrData[WORD_W-1:LK_ALIGN];
      if (ptrHiWr) ptrHiR <= wrData;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      curAddr <= '0;
      wordIdx <= '0;
    end else if (stb.loadPtr) begin
      curAddr <= {ptrHiR, ptrLoR, {LK_ALIGN{1'b0}}};
      wordIdx <= '0;
    end else if (stb.followNext) begin
      curAddr <= nextAddr;
      wordIdx <= '0;
    end else if (stb.capWord) begin
      wordIdx <= lastWord ? '0 : wordIdx + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      hostLoR <= '0;
      hostHiR <= '0;
      bytesR  <= '0;
      linkLoR <= '0;
      linkHiR <= '0;
    end else if (stb.capWord) begin
      case (wordIdx)
        IDX_W'(DW_HOST_LO): hostLoR <= memRdData;
        IDX_W'(DW_HOST_HI): hostHiR <= memRdData;
        IDX_W'(DW_BYTES):   bytesR  <= memRdData;
        IDX_W'(DW_LINK_LO): linkLoR <= memRdData;
        IDX_W'(DW_LINK_HI): linkHiR <= memRdData;
        default: ;
      endcase
    end
  end

  // R4
  word_align_chk: assert property (@(posedge clk) disable iff (!rstN)
    memRdAddr[1:0] == 2'b00);

endmodule

// File: rtl/sg_chain_ctrl.sv
module sg_chain_ctrl
  import sg_chain_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              ctrlWr,
  input  logic [WORD_W-1:0] wrData,
  input  logic              memRdValid,
  input  logic              lastWord,
  input  logic              eocFlag,
  input  logic              irqFlag,
  input  logic              xferReady,
  input  logic              xferDone,
  input  logic              eventIn,
  output dpStrobe_t         stb,
  output logic              memRdReq,
  output logic              xferValid,
  output logic [WORD_W-1:0] csrQ,
  output logic              irq
);

  engState_t state;
  logic enQ, sgModeQ, evEnQ, doneQ, sgIrqQ, evIrqQ;
  logic abortCmd, startCmd, descDone;

  assign abortCmd = ctrlWr && wrData[CS_ABORT];
  assign startCmd = ctrlWr && wrData[CS_EN] && wrData[CS_START] &&
                    wrData[CS_SGMODE] && !wrData[CS_ABORT] && (state == ST_IDLE);
  assign descDone = (state == ST_WAIT) && xferDone && !abortCmd;

  assign memRdReq  = (state == ST_FETCH);
  assign xferValid = (state == ST_ISSUE);

  always_comb begin
    stb            = '0;
    stb.loadPtr    = startCmd;
    stb.capWord    = (state == ST_FETCH) && memRdValid && !abortCmd;
    stb.followNext = descDone && !eocFlag;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= ST_IDLE;
      doneQ <= 1'b1;
    end else if (abortCmd) begin
      state <= ST_IDLE;
      doneQ <= 1'b1;
    end else begin
      case (state)
        ST_IDLE:  if (startCmd) begin
                    state <= ST_FETCH;
                    doneQ <= 1'b0;
                  end
        ST_FETCH: if (memRdValid && lastWord) state <= ST_ISSUE;
        ST_ISSUE: if (xferReady) state <= ST_WAIT;
        ST_WAIT:  if (xferDone) begin
                    if (eocFlag) begin
                      state <= ST_IDLE;
                      doneQ <= 1'b1;
                    end else begin
                      state <= ST_FETCH;
                    end
                  end
        default:  state <= ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      enQ     <= 1'b0;
      sgModeQ <= 1'b0;
      evEnQ   <= 1'b0;
      sgIrqQ  <= 1'b0;
      evIrqQ  <= 1'b0;
    end else begin
      if (ctrlWr) begin
        enQ     <= wrData[CS_EN];
        sgModeQ <= wrData[CS_SGMODE];
        evEnQ   <= wrData[CS_EVIRQEN];
      end
      if (descDone && irqFlag)              sgIrqQ <= 1'b1;
      else if (ctrlWr && wrData[CS_SGIRQ])  sgIrqQ <= 1'b0;
      if (eventIn)                          evIrqQ <= 1'b1;
      else if (ctrlWr && wrData[CS_EVIRQ])  evIrqQ <= 1'b0;
    end
  end

  always_comb begin
    csrQ             = '0;
    csrQ[CS_EN]      = enQ;
    csrQ[CS_DONE]    = doneQ;
    csrQ[CS_SGIRQ]   = sgIrqQ;
    csrQ[CS_EVIRQ]   = evIrqQ;
    csrQ[CS_SGMODE]  = sgModeQ;
    csrQ[CS_EVIRQEN] = evEnQ;
  end

  assign irq = sgIrqQ | (evIrqQ & evEnQ);

  // R10
  abort_sets_done_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ctrlWr && wrData[CS_ABORT]) |=> (doneQ && !memRdReq && !xferValid));

  // R7
  done_needs_ack_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(doneQ) |-> ($past(xferDone) || $past(ctrlWr && wrData[CS_ABORT])));

  // R8
  sg_irq_source_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(sgIrqQ) |-> $past(xferDone && irqFlag));

  // R7
  start_clears_done_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(memRdReq) && $past(state == ST_IDLE) |-> !doneQ);

endmodule

// File: rtl/sg_chain_engine.sv
module sg_chain_engine
  import sg_chain_pkg::*;
#(
  parameter int DESC_WORDS = 8
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        regWrEn,
  input  logic [3:0]  regAddr,
  input  logic [31:0] regWrData,
  output logic [31:0] regRdData,
  output logic        memRdReq,
  output logic [63:0] memRdAddr,
  input  logic        memRdValid,
  input  logic [31:0] memRdData,
  output logic        xferValid,
  output logic [63:0] xferHostAddr,
  output logic [31:0] xferBytes,
  output logic        xferToHost,
  input  logic        xferReady,
  input  logic        xferDone,
  input  logic        eventIn,
  output logic        irq
);

  dpStrobe_t         stb;
  logic [WORD_W-1:0] ptrLoQ, ptrHiQ, csrQ;
  logic              lastWord, eocFlag, irqFlag;
  logic [1:0]        regIdx;

  assign regIdx = regAddr[3:2];

  sg_chain_dpath #(.DESC_WORDS(DESC_WORDS)) u_dpath (
    .clk        (clk),
    .rstN       (rstN),
    .stb        (stb),
    .ptrLoWr    (regWrEn && regIdx == RA_PTR_LO),
    .ptrHiWr    (regWrEn && regIdx == RA_PTR_HI),
    .wrData     (regWrData),
    .memRdData  (memRdData),
    .ptrLoQ     (ptrLoQ),
    .ptrHiQ     (ptrHiQ),
    .memRdAddr  (memRdAddr),
    .lastWord   (lastWord),
    .eocFlag    (eocFlag),
    .irqFlag    (irqFlag),
    .toHostFlag (xferToHost),
    .hostAddr   (xferHostAddr),
    .byteCount  (xferBytes)
  );

  sg_chain_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .ctrlWr     (regWrEn && regIdx == RA_CTRL),
    .wrData     (regWrData),
    .memRdValid (memRdValid),
    .lastWord   (lastWord),
    .eocFlag    (eocFlag),
    .irqFlag    (irqFlag),
    .xferReady  (xferReady),
    .xferDone   (xferDone),
    .eventIn    (eventIn),
    .stb        (stb),
    .memRdReq   (memRdReq),
    .xferValid  (xferValid),
    .csrQ       (csrQ),
    .irq        (irq)
  );

  always_comb begin
    case (regIdx)
      RA_PTR_LO: regRdData = ptrLoQ;
      RA_PTR_HI: regRdData = ptrHiQ;
      RA_CTRL:   regRdData = csrQ;
      default:   regRdData = '0;
    endcase
  end

  // R5
  cmd_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (xferValid && !xferReady) |=> (xferValid && $stable(xferHostAddr) &&
                                   $stable(xferBytes) && $stable(xferToHost)));

endmodule

// File: tb/sg_chain_engine_tb.sv
module sg_chain_engine_tb;

  typedef struct {
    logic [63:0] addr;
    logic [31:0] bytes;
    logic        toHost;
  } xferExp_t;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWrEn = 1'b0;
  logic [3:0]  regAddr = 4'd0;
  logic [31:0] regWrData = '0;
  logic [31:0] regRdData;
  logic        memRdReq;
  logic [63:0] memRdAddr;
  logic        memRdValid = 1'b0;
  logic [31:0] memRdData = '0;
  logic        xferValid;
  logic [63:0] xferHostAddr;
  logic [31:0] xferBytes;
  logic        xferToHost;
  logic        xferReady = 1'b0;
  logic        xferDone = 1'b0;
  logic        eventIn = 1'b0;
  logic        irq;

  int total = 0;
  int bad = 0;
  int acceptCount = 0;
  int memReqSeen = 0;
  int xferSeen = 0;
  int moverCnt = 0;
  logic [31:0] mem [logic [63:0]];
  xferExp_t    expQ [$];

  always #4 clk = ~clk;

  sg_chain_engine u_dut (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData), .memRdReq(memRdReq),
    .memRdAddr(memRdAddr), .memRdValid(memRdValid), .memRdData(memRdData),
    .xferValid(xferValid), .xferHostAddr(xferHostAddr), .xferBytes(xferBytes),
    .xferToHost(xferToHost), .xferReady(xferReady), .xferDone(xferDone),
    .eventIn(eventIn), .irq(irq)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // memory model: answers in the cycle of the request
  always @(negedge clk) begin
    memRdValid = memRdReq;
    if (memRdReq) begin
      memReqSeen++;
      memRdData = mem.exists(memRdAddr) ? mem[memRdAddr] : 32'hDEAD_BEEF;
    end
  end

  // mover + scoreboard monitor
  always @(negedge clk) begin
    xferDone = 1'b0;
    if (moverCnt > 0) begin
      moverCnt--;
      if (moverCnt == 0) xferDone = 1'b1;
    end
    if (xferValid) xferSeen++;
    if (xferReady) begin
      xferReady = 1'b0;
    end else if (xferValid && moverCnt == 0 && !xferDone) begin
      if (expQ.size() == 0) begin
        chk("R5 unexpected transfer", 64'd1, 64'd0);
      end else begin
        xferExp_t e;
        e = expQ.pop_front();
        chk("R5 R6 host address", xferHostAddr, e.addr);
        chk("R5 byte count", {32'd0, xferBytes}, {32'd0, e.bytes});
        chk("R5 direction", {63'd0, xferToHost}, {63'd0, e.toHost});
      end
      xferReady = 1'b1;
      moverCnt = 4;
      acceptCount++;
    end
  end

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    regWrEn = 1'b1; regAddr = a; regWrData = d;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk);
    regAddr = a;
    #1;
    d = regRdData;
  endtask

  task automatic putDesc(input logic [63:0] at, input logic [63:0] host,
                         input logic [31:0] bytes, input logic [31:0] lkLo,
                         input logic [31:0] lkHi);
    mem[at]      = host[31:0];
    mem[at + 4]  = host[63:32];
    mem[at + 8]  = 32'h1111_1111;
    mem[at + 12] = 32'd0;
    mem[at + 16] = bytes;
    mem[at + 20] = 32'd0;
    mem[at + 24] = lkLo;
    mem[at + 28] = lkHi;
  endtask

  task automatic pushExp(input logic [63:0] a, input logic [31:0] b, input logic t);
    xferExp_t e;
    e.addr = a; e.bytes = b; e.toHost = t;
    expQ.push_back(e);
  endtask

  task automatic startChain(input logic [63:0] p);
    wr(4'h4, p[63:32]);
    wr(4'h0, p[31:0]);
    wr(4'h8, 32'h0000_0103);
  endtask

  task automatic waitDone(input string req);
    logic [31:0] d;
    d = '0;
    for (int i = 0; i < 400; i++) begin
      rd(4'h8, d);
      if (d[4]) break;
    end
    chk(req, {63'd0, d[4]}, 64'd1);
  endtask

  task automatic finishRun();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++;
    $display("FAIL watchdog expired");
    finishRun();
  end

  initial begin
    logic [31:0] d;
    int base, seen;

    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1 reset state
    rd(4'h8, d);
    chk("R1 csr", {32'd0, d}, 64'h10);
    chk("R1 irq", {63'd0, irq}, 64'd0);
    chk("R1 memRdReq", {63'd0, memRdReq}, 64'd0);
    chk("R1 xferValid", {63'd0, xferValid}, 64'd0);

    // R2 pointer registers
    wr(4'h0, 32'h1234_567F);
    rd(4'h0, d);
    chk("R2 low word", {32'd0, d}, 64'h1234_5660);
    wr(4'h4, 32'hABCD_0001);
    rd(4'h4, d);
    chk("R2 high word", {32'd0, d}, 64'hABCD_0001);

    // R3 incomplete start writes
    seen = memReqSeen;
    wr(4'h8, 32'h0000_0003);
    wr(4'h8, 32'h0000_0102);
    repeat (10) @(negedge clk);
    chk("R3 no fetch", memReqSeen, seen);
    rd(4'h8, d);
    chk("R3 done kept", {63'd0, d[4]}, 64'd1);

    // R4 R5 R6 R7 R8: three-entry chain, last has end + interrupt
    putDesc(64'h1000, 64'h0000_0002_0000_0100, 32'h40, 32'h0000_2048, 32'h0);
    putDesc(64'h2040, 64'h0000_0000_8000_0000, 32'h100, 32'h0000_0020, 32'h1);
    putDesc(64'h1_0000_0020, 64'h0000_0003_0000_0FFC, 32'h4, 32'h0000_000E, 32'h0);
    pushExp(64'h0000_0002_0000_0100, 32'h40, 1'b1);
    pushExp(64'h0000_0000_8000_0000, 32'h100, 1'b0);
    pushExp(64'h0000_0003_0000_0FFC, 32'h4, 1'b1);
    base = acceptCount;
    startChain(64'h1000);
    rd(4'h8, d);
    chk("R7 start clears done", {63'd0, d[4]}, 64'd0);
    wait (acceptCount == base + 3);
    rd(4'h8, d);
    chk("R7 done waits for ack", {63'd0, d[4]}, 64'd0);
    waitDone("R7 done after last ack");
    chk("R4 R6 all transfers", acceptCount - base, 3);
    rd(4'h8, d);
    chk("R8 sg irq bit", {63'd0, d[5]}, 64'd1);
    chk("R8 irq out", {63'd0, irq}, 64'd1);
    wr(4'h8, 32'h0000_0020);
    rd(4'h8, d);
    chk("R8 w1c", {63'd0, d[5]}, 64'd0);
    chk("R8 irq cleared", {63'd0, irq}, 64'd0);

    // R9 event interrupt
    @(negedge clk); eventIn = 1'b1;
    @(negedge clk); eventIn = 1'b0;
    rd(4'h8, d);
    chk("R9 event bit", {63'd0, d[6]}, 64'd1);
    chk("R9 gated off", {63'd0, irq}, 64'd0);
    wr(4'h8, 32'h0000_0400);
    rd(4'h8, d);
    chk("R9 gated on", {63'd0, irq}, 64'd1);
    wr(4'h8, 32'h0000_0440);
    rd(4'h8, d);
    chk("R9 w1c", {63'd0, d[6]}, 64'd0);
    chk("R9 irq cleared", {63'd0, irq}, 64'd0);

    // R6 R10: endless two-entry loop, then abort
    putDesc(64'h3000, 64'h5000, 32'h20, 32'h0000_3020, 32'h0);
    putDesc(64'h3020, 64'h6000, 32'h24, 32'h0000_3008, 32'h0);
    for (int k = 0; k < 4; k++) begin
      pushExp(64'h5000, 32'h20, 1'b0);
      pushExp(64'h6000, 32'h24, 1'b1);
    end
    base = acceptCount;
    startChain(64'h3000);
    wait (acceptCount == base + 5);
    wr(4'h8, 32'h0000_0004);
    expQ.delete();
    rd(4'h8, d);
    chk("R10 done after abort", {63'd0, d[4]}, 64'd1);
    seen = memReqSeen;
    base = xferSeen;
    repeat (20) @(negedge clk);
    chk("R10 no fetch", memReqSeen, seen);
    chk("R10 no command", xferSeen, base);
    rd(4'h8, d);
    chk("R10 done held", {63'd0, d[4]}, 64'd1);
    chk("R8 no flag no irq", {63'd0, d[5]}, 64'd0);

    // R7 restart after abort, single entry
    putDesc(64'h4000, 64'h7000, 32'h8, 32'h0000_0002, 32'h0);
    pushExp(64'h7000, 32'h8, 1'b0);
    base = acceptCount;
    startChain(64'h4000);
    waitDone("R7 restart done");
    chk("R7 single transfer", acceptCount - base, 1);
    chk("R5 queue drained", expQ.size(), 0);

    finishRun();
  end

endmodule